// File: doc/BRIEF.md
# Block-Transfer Micro-Op Cracker

This block takes one decoded block-transfer instruction and turns it into a stream of simpler micro-ops, one at a time. The instruction names a base register, a condition, a five-bit addressing-mode field and a register list. The block issues micro-ops in a fixed order. First comes a copy of the base register. Next comes one load or store for each register in the list. Last, if the mode asks for it, an add or subtract writes the updated address back to the base register.

A front end pulses `startIn` with the instruction on `instrIn`. Each micro-op is held on the outputs while `validOut` is high and moves on only when the consumer raises `readyIn`. `lastOut` marks the final micro-op. A mode code the block does not support produces a one-cycle `errOut` pulse and no micro-ops.

Instruction layout used by the block: bits [31:28] condition, [24:20] mode (bit 24 pre-index, 23 up, 22 user-bank, 21 writeback, 20 load), [19:16] base register, [15:0] register list.

Top module: `blkxfer_cracker`

## Requirements
- R1: An accepted instruction yields exactly popcount(list) + 1 + (mode bit 1) micro-ops. `validOut` is low again after the last of them is taken.
- R2: The first micro-op has kind 0 (base copy) and offset 0. Its word equals the instruction with bits [15:0] cleared.
- R3: The load/store micro-ops (kind 1) carry the indices of the set bits of the list in ascending order. Their word is the unchanged instruction.
- R4: The offset of the first load/store depends on the mode code. For codes 0x01 and 0x03 it is popcount*4-4. For 0x08, 0x09 and 0x0B it is 0. For 0x11 and 0x12 it is popcount*4. For 0x18 and 0x19 it is 4.
- R5: Each following load/store offset is the previous one plus 4 when mode bit 3 (up) is set, and minus 4 when it is clear. The arithmetic wraps at 32 bits.
- R6: A start with any mode code other than the nine in R4 pulses `errOut` for exactly one cycle, in the cycle after the start, and issues no micro-op.
- R7: The writeback word is built from the instruction's bits [31:28], OR 0x02400000, with the base register in bits [19:16] and again in bits [15:12], and popcount*4 in bits [7:0].
- R8: The writeback micro-op is always the final one. Its kind is 2 (add) when the up bit is set and 3 (subtract) when it is clear.
- R9: `lastOut` is high on the final micro-op of a sequence and on no other.
- R10: A micro-op is consumed only on a cycle with `validOut` and `readyIn` both high. While `readyIn` is low the outputs hold. A start pulse arriving while a sequence is in progress is ignored.
- R11: With an empty list the sequence is the base copy followed by the optional writeback, and `lastOut` is on whichever of the two comes last.
- R12: After reset `validOut` and `errOut` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrIn | input | 32 | Instruction word, sampled on the start cycle |
| startIn | input | 1 | Start pulse, accepted only while idle |
| readyIn | input | 1 | Consumer can take the current micro-op |
| validOut | output | 1 | A micro-op is presented |
| lastOut | output | 1 | Current micro-op is the final one |
| kindOut | output | 2 | 0 base copy, 1 load/store, 2 writeback add, 3 writeback subtract |
| regIdxOut | output | 4 | Register index for a load/store micro-op |
| offsetOut | output | 32 | Byte offset for a load/store micro-op, 0 otherwise |
| wordOut | output | 32 | Encoded instruction word of the micro-op |
| errOut | output | 1 | One-cycle pulse for an unsupported mode |

## Verification
Several rules are checked by assertions on every cycle. Outputs hold while the consumer stalls. An error pulse never coincides with a valid micro-op. `lastOut` appears only with `validOut`, and a taken final micro-op leaves the block idle. Each load/store step removes exactly one register from the remaining list. The bench alone can show the full contents of each micro-op: the count, the per-mode starting offsets, the ascending register order, the bit layout of the writeback word and the rejection of unsupported modes. To do this it sweeps all 32 mode codes over a set of register lists and stall patterns, and also pulses start during busy, stalled cycles.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

  typedef enum logic [1:0] {
    UOP_BASE   = 2'd0,
    UOP_XFER   = 2'd1,
    UOP_WB_ADD = 2'd2,
    UOP_WB_SUB = 2'd3
  } uopKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture a new instruction
    logic step;   // retire one load/store micro-op
  } seqStrobe_t;

  localparam int INSTR_W   = 32;
  localparam int MODE_LSB  = 20;
  localparam int MODE_W    = 5;
  localparam int RN_LSB    = 16;
  localparam int COND_LSB  = 28;

endpackage

// File: rtl/blkxfer_dpath.sv
module blkxfer_dpath
  import blkxfer_pkg::*;
#(
  parameter int LIST_W = 16,
  parameter int OFS_W  = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [INSTR_W-1:0]        instrIn,
  input  seqStrobe_t                strb,
  input  uopKind_e                  kind,
  output logic                      modeOk,
  output logic                      wbEn,
  output logic                      upDir,
  output logic                      remAny,
  output logic                      remLast,
  output logic [$clog2(LIST_W)-1:0] regIdx,
  output logic [OFS_W-1:0]          offset,
  output logic [INSTR_W-1:0]        word
);

  localparam int IDX_W = $clog2(LIST_W);
  localparam int CNT_W = $clog2(LIST_W + 1);

  logic [INSTR_W-1:0] instrQ;
  logic [LIST_W-1:0]  remQ;
  logic [OFS_W-1:0]   ofsQ;
  logic [CNT_W-1:0]   cntQ;
  logic [CNT_W-1:0]   cntIn;
  logic [OFS_W-1:0]   ofsStart;
  logic [MODE_W-1:0]  modeIn;
  logic [LIST_W-1:0]  remNext;

  assign modeIn = instrIn[MODE_LSB +: MODE_W];

  always_comb begin
    cntIn = '0;
    for (int i = 0; i < LIST_W; i++) cntIn = cntIn + CNT_W'(instrIn[i]);
  end

  // supported mode codes and their starting offsets
  always_comb begin
    modeOk   = 1'b1;
    ofsStart = '0;
    case (modeIn)
      5'h01, 5'h03:        ofsStart = (OFS_W'(cntIn) << 2) - OFS_W'(4);
      5'h08, 5'h09, 5'h0B: ofsStart = '0;
      5'h11, 5'h12:        ofsStart = OFS_W'(cntIn) << 2;
      5'h18, 5'h19:        ofsStart = OFS_W'(4);
      default:             modeOk   = 1'b0;
    endcase
  end

  assign remNext = remQ & (remQ - LIST_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      instrQ <= '0;
      remQ   <= '0;
      ofsQ   <= '0;
      cntQ   <= '0;
    end else if (strb.load) begin
      instrQ <= instrIn;
      remQ   <= instrIn[LIST_W-1:0];
      ofsQ   <= ofsStart;
      cntQ   <= cntIn;
    end else if (strb.step) begin
      remQ <= remNext;
      ofsQ <= upDir ? ofsQ + OFS_W'(4) : ofsQ - OFS_W'(4);
    end
  end

  // lowest remaining set bit
  always_comb begin
    regIdx = '0;
    for (int i = LIST_W - 1; i >= 0; i--) if (remQ[i]) regIdx = IDX_W'(i);
  end

  assign wbEn    = instrQ[MODE_LSB + 1];
  assign upDir   = instrQ[MODE_LSB + 3];
  assign remAny  = |remQ;
  assign remLast = remAny && (remNext == '0);

  logic [3:0]         rnQ;
  logic [INSTR_W-1:0] wbWord;
  assign rnQ    = instrQ[RN_LSB +: 4];
  assign wbWord = {instrQ[INSTR_W-1:COND_LSB], {COND_LSB{1'b0}}}
                | 32'h0240_0000
                | (INSTR_W'(rnQ) << 16)
                | (INSTR_W'(rnQ) << 12)
                | (INSTR_W'(cntQ) << 2);

  always_comb begin
    word   = instrQ;
    offset = '0;
    unique case (kind)
      UOP_BASE:               word = {instrQ[INSTR_W-1:16], 16'h0000};
      UOP_XFER:               offset = ofsQ;
      UOP_WB_ADD, UOP_WB_SUB: word = wbWord;
    endcase
  end

  // each load/store step removes exactly one register
  assert_step_one_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |=> $countones(remQ) + 1 == $countones($past(remQ)));

  // step only happens with registers left
  assert_step_nonempty_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |-> remAny);

endmodule

// File: rtl/blkxfer_ctrl.sv
module blkxfer_ctrl
  import blkxfer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startIn,
  input  logic       readyIn,
  input  logic       modeOk,
  input  logic       wbEn,
  input  logic       upDir,
  input  logic       remAny,
  input  logic       remLast,
  output seqStrobe_t strb,
  output uopKind_e   kind,
  output logic       validOut,
  output logic       lastOut,
  output logic       errOut
);

  typedef enum logic [1:0] {S_IDLE, S_BASE, S_XFER, S_WB} seqState_e;

  seqState_e stateQ, stateD;
  logic      errQ;
  logic      fire;

  assign validOut = (stateQ != S_IDLE);
  assign fire     = validOut && readyIn;

  always_comb begin
    strb.load = (stateQ == S_IDLE) && startIn && modeOk;
    strb.step = (stateQ == S_XFER) && fire;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      S_IDLE: if (strb.load) stateD = S_BASE;
      S_BASE: if (fire) stateD = remAny ? S_XFER : (wbEn ? S_WB : S_IDLE);
      S_XFER: if (fire && remLast) stateD = wbEn ? S_WB : S_IDLE;
      S_WB:   if (fire) stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      errQ   <= 1'b0;
    end else begin
      stateQ <= stateD;
      errQ   <= (stateQ == S_IDLE) && startIn && !modeOk;
    end
  end

  always_comb begin
    unique case (stateQ)
      S_XFER:  kind = UOP_XFER;
      S_WB:    kind = upDir ? UOP_WB_ADD : UOP_WB_SUB;
      default: kind = UOP_BASE;
    endcase
    lastOut = ((stateQ == S_BASE) && !remAny && !wbEn)
           || ((stateQ == S_XFER) && remLast && !wbEn)
           ||  (stateQ == S_WB);
  end

  assign errOut = errQ;

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    validOut && !readyIn |=> validOut && $stable(kind) && $stable(lastOut));

  assert_err_no_valid_R6: assert property (@(posedge clk) disable iff (!rstN)
    errOut |-> !validOut);

  assert_last_valid_R9: assert property (@(posedge clk) disable iff (!rstN)
    lastOut |-> validOut);

  assert_last_ends_R9: assert property (@(posedge clk) disable iff (!rstN)
    validOut && readyIn && lastOut |=> !validOut);

endmodule

// File: rtl/blkxfer_cracker.sv
module blkxfer_cracker
  import blkxfer_pkg::*;
#(
  parameter int LIST_W = 16,
  parameter int OFS_W  = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [31:0]               instrIn,
  input  logic                      startIn,
  input  logic                      readyIn,
  output logic                      validOut,
  output logic                      lastOut,
  output logic [1:0]                kindOut,
  output logic [$clog2(LIST_W)-1:0] regIdxOut,
  output logic [OFS_W-1:0]          offsetOut,
  output logic [31:0]               wordOut,
  output logic                      errOut
);

  seqStrobe_t strb;
  uopKind_e   kind;
  logic       modeOk, wbEn, upDir, remAny, remLast;

  blkxfer_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .startIn(startIn), .readyIn(readyIn),
    .modeOk(modeOk), .wbEn(wbEn), .upDir(upDir), .remAny(remAny),
    .remLast(remLast), .strb(strb), .kind(kind), .validOut(validOut),
    .lastOut(lastOut), .errOut(errOut)
  );

  blkxfer_dpath #(.LIST_W(LIST_W), .OFS_W(OFS_W)) dpath_i (
    .clk(clk), .rstN(rstN), .instrIn(instrIn), .strb(strb), .kind(kind),
    .modeOk(modeOk), .wbEn(wbEn), .upDir(upDir), .remAny(remAny),
    .remLast(remLast), .regIdx(regIdxOut), .offset(offsetOut), .word(wordOut)
  );

  assign kindOut = kind;

endmodule

// File: tb/blkxfer_cracker_tb_top.sv
`timescale 1ns/1ps
module blkxfer_cracker_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] instrIn = '0;
  logic        startIn = 1'b0;
  logic        readyIn = 1'b1;
  logic        validOut, lastOut, errOut;
  logic [1:0]  kindOut;
  logic [3:0]  regIdxOut;
  logic [31:0] offsetOut, wordOut;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  blkxfer_cracker dut_i (
    .clk(clk), .rstN(rstN), .instrIn(instrIn), .startIn(startIn),
    .readyIn(readyIn), .validOut(validOut), .lastOut(lastOut),
    .kindOut(kindOut), .regIdxOut(regIdxOut), .offsetOut(offsetOut),
    .wordOut(wordOut), .errOut(errOut)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit modeSupported(input int m);
    return m == 1 || m == 3 || m == 8 || m == 9 || m == 11 ||
           m == 17 || m == 18 || m == 24 || m == 25;
  endfunction

  // expected micro-op k of the sequence for instruction ins
  task automatic expectUop(input logic [31:0] ins, input int k,
                           output int eKind, output int eIdx,
                           output logic [31:0] eOfs, output logic [31:0] eWord,
                           output bit eLast);
    int m, c, total, seen;
    logic [31:0] start;
    bit up, wb;
    m  = int'(ins[24:20]);
    c  = $countones(ins[15:0]);
    up = ins[23];
    wb = ins[21];
    total = c + 1 + int'(wb);
    case (m)
      1, 3:      start = 32'(c * 4) - 32'd4;
      17, 18:    start = 32'(c * 4);
      24, 25:    start = 32'd4;
      default:   start = 32'd0;
    endcase
    eIdx = 0; eOfs = 0; eWord = ins; eLast = (k == total - 1);
    if (k == 0) begin
      eKind = 0; eWord = {ins[31:16], 16'h0};
    end else if (k <= c) begin
      eKind = 1;
      seen = 0;
      for (int i = 0; i < 16; i++)
        if (ins[i]) begin
          seen++;
          if (seen == k) eIdx = i;
        end
      eOfs = up ? start + 32'(4 * (k - 1)) : start - 32'(4 * (k - 1));
    end else begin
      eKind = up ? 2 : 3;
      eWord = {ins[31:28], 28'h0} | 32'h0240_0000 | (32'(ins[19:16]) << 16)
            | (32'(ins[19:16]) << 12) | 32'(c * 4);
    end
  endtask

  task automatic checkUop(input logic [31:0] ins, input int k);
    int eKind, eIdx; logic [31:0] eOfs, eWord; bit eLast;
    expectUop(ins, k, eKind, eIdx, eOfs, eWord, eLast);
    check(validOut === 1'b1, "R1 valid during sequence", 32'(validOut), 32'd1);
    check(kindOut == 2'(eKind), eKind == 0 ? "R2 base kind" :
          (eKind == 1 ? "R3 xfer kind" : "R8 writeback kind"),
          32'(kindOut), 32'(eKind));
    check(wordOut == eWord, eKind == 0 ? "R2 base word" :
          (eKind == 1 ? "R3 xfer word" : "R7 writeback word"), wordOut, eWord);
    check(offsetOut == eOfs, k <= 1 ? "R4 offset" : "R5 offset step",
          offsetOut, eOfs);
    if (eKind == 1)
      check(regIdxOut == 4'(eIdx), "R3 register order", 32'(regIdxOut), 32'(eIdx));
    if (ins[15:0] == 16'h0)
      check(lastOut == eLast, "R11 last with empty list", 32'(lastOut), 32'(eLast));
    else
      check(lastOut == eLast, "R9 last flag", 32'(lastOut), 32'(eLast));
  endtask

  task automatic runOne(input logic [31:0] ins, input int seed);
    int total;
    total = $countones(ins[15:0]) + 1 + int'(ins[21]);
    @(negedge clk);
    instrIn = ins; startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    if (!modeSupported(int'(ins[24:20]))) begin
      check(errOut === 1'b1, "R6 error pulse", 32'(errOut), 32'd1);
      check(validOut === 1'b0, "R6 no micro-op", 32'(validOut), 32'd0);
      @(negedge clk);
      check(errOut === 1'b0, "R6 pulse one cycle", 32'(errOut), 32'd0);
      check(validOut === 1'b0, "R6 still idle", 32'(validOut), 32'd0);
      return;
    end
    check(errOut === 1'b0, "R6 no error on supported mode", 32'(errOut), 32'd0);
    for (int k = 0; k < total; k++) begin
      if (((seed * 7 + k * 3) % 5) == 0) begin
        readyIn = 1'b0;
        startIn = 1'b1;          // ignored while busy
        instrIn = ~ins;
        @(negedge clk);
        startIn = 1'b0;
        instrIn = ins;
        checkUop(ins, k);        // R10 held through stall
        check(errOut === 1'b0, "R10 busy start ignored", 32'(errOut), 32'd0);
      end
      readyIn = 1'b1;
      checkUop(ins, k);
      @(negedge clk);
    end
    check(validOut === 1'b0, "R1 count ends sequence", 32'(validOut), 32'd0);
  endtask

  bit done = 1'b0;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lists [8];
    lists[0] = 16'h0000; lists[1] = 16'h0001; lists[2] = 16'h8000;
    lists[3] = 16'hFFFF; lists[4] = 16'h1234; lists[5] = 16'hA005;
    lists[6] = 16'h0F00; lists[7] = 16'h4002;
    repeat (3) @(negedge clk);
    check(validOut === 1'b0, "R12 reset valid", 32'(validOut), 32'd0);
    check(errOut === 1'b0, "R12 reset error", 32'(errOut), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(validOut === 1'b0, "R12 idle after reset", 32'(validOut), 32'd0);
    for (int m = 0; m < 32; m++)
      for (int l = 0; l < 8; l++) begin
        logic [31:0] ins;
        ins = {4'((m + l) & 15), 3'b100, 5'(m), 4'((m * 3 + l) & 15), lists[l]};
        runOne(ins, m * 8 + l);
      end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule